// File: doc/BRIEF.md
# Clock-Driven Step Sequencer with Post-Reset Clock Holdoff

This block walks a step index through a fixed number of positions and advances one position on each rising edge of an external clock signal. The inputs are slow control signals (clock, reset trigger and run trigger) that are examined once per sample tick. A rising edge on the reset trigger returns the index to zero. A rising edge on the run trigger toggles between stopped and running.

Clock edges often arrive late, or fire as a side effect of a reset or a restart. Either case would make the sequencer skip its first step. To prevent this, a reset edge or a stopped-to-running change opens a holdoff window of a set number of sample ticks. Any clock edge seen inside that window is discarded for good. After the window closes, the next real clock edge moves the index off step 0. The window length is a parameter. At a 48 kHz tick rate, 48 ticks gives 1 ms, which suits clocks up to 1 kHz. A shorter window, such as 0.1 ms, is set the same way.

Top module: `step_seq_holdoff`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `step_o` is 0 and `running_o` is 0.
- R2: A rising edge on `run_trig_i`, seen on a tick, inverts `running_o` on the following clock cycle.
- R3: When running and outside the holdoff window, a rising edge on `seq_clk_i` raises `step_o` by exactly one on the clock cycle after the tick.
- R4: `step_o` wraps from STEPS-1 back to 0 and never holds a value of STEPS or more.
- R5: While stopped, clock edges leave `step_o` unchanged.
- R6: A rising edge on `reset_trig_i` sets `step_o` to 0 on the next cycle, whatever the run state, and leaves `running_o` unchanged.
- R7: When a reset edge is seen at tick T, clock edges at ticks T through T+HOLD_TICKS are ignored. A clock edge at tick T+HOLD_TICKS+1 advances the step.
- R8: A change from stopped to running at tick T opens the same window, so a clock edge at ticks T through T+HOLD_TICKS is ignored.
- R9: A reset edge that arrives while a window is open restarts the window at full length.
- R10: Inputs are sampled only on cycles with `tick_en` high. A level is an edge only when it differs from the level at the previous tick. An edge dropped in the window is never replayed later, even if the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sample-rate tick enable, one cycle wide |
| seq_clk_i | input | 1 | Step clock level |
| reset_trig_i | input | 1 | Reset trigger level |
| run_trig_i | input | 1 | Run toggle trigger level |
| step_o | output | $clog2(STEPS) | Current step index |
| running_o | output | 1 | High while the sequencer runs |

## Verification
Three kinds of wrong internal state show up at the ports. If the holdoff counter is off by one or fails to restart, a step is taken one tick early, or one tick late, at the window boundary. The checks look at that exact tick. If the run state is wrong, a clock edge that should be ignored moves `step_o` instead, or the reverse. If the edge-history registers are wrong, a held-high input produces a phantom advance. Each of these faults is visible on the cycle right after the tick that exposes it.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  // Positions of the sampled control inputs inside the edge vector
  localparam int unsigned SIG_CLK = 0;
  localparam int unsigned SIG_RST = 1;
  localparam int unsigned SIG_RUN = 2;
  localparam int unsigned SIG_NUM = 3;

  typedef struct packed {
    logic run;
    logic rst;
    logic clk;
  } seq_edges_t;

endpackage

// File: rtl/seq_edge_detect.sv
module seq_edge_detect #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      prev_d[g] = prev_q[g];
      if (tick_en) prev_d[g] = lvl_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= prev_d[g];
    end

    assign rise_o[g] = tick_en & lvl_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/seq_holdoff_timer.sv
module seq_holdoff_timer #(
  parameter int unsigned HOLD_TICKS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)                       cnt_d = LOAD;
    else if (tick_en && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter #(
  parameter int unsigned STEPS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     adv_i,
  output logic [$clog2(STEPS)-1:0] step_o
);

  localparam int unsigned SW = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic [SW-1:0] step_q;
  logic [SW-1:0] step_d;

  always_comb begin
    step_d = step_q;
    if (clr_i)      step_d = '0;
    else if (adv_i) step_d = (step_q == LAST) ? '0 : step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step_o = step_q;

endmodule

// File: rtl/step_seq_holdoff.sv
module step_seq_holdoff
  import step_seq_pkg::*;
#(
  parameter int unsigned STEPS      = 16,
  parameter int unsigned HOLD_TICKS = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     seq_clk_i,
  input  logic                     reset_trig_i,
  input  logic                     run_trig_i,
  output logic [$clog2(STEPS)-1:0] step_o,
  output logic                     running_o
);

  logic [SIG_NUM-1:0] lvl;
  logic [SIG_NUM-1:0] rise;
  seq_edges_t         ev;

  logic run_q;
  logic run_d;
  logic hold_start;
  logic hold_busy;
  logic step_adv;

  assign lvl[SIG_CLK] = seq_clk_i;
  assign lvl[SIG_RST] = reset_trig_i;
  assign lvl[SIG_RUN] = run_trig_i;

  seq_edge_detect #(.W(SIG_NUM)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  assign ev.clk = rise[SIG_CLK];
  assign ev.rst = rise[SIG_RST];
  assign ev.run = rise[SIG_RUN];

  // Run state toggles on each run trigger edge
  always_comb begin
    run_d = run_q;
    if (ev.run) run_d = ~run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  // Window opens on reset edge or on stopped -> running
  assign hold_start = ev.rst | (ev.run & ~run_q);

  seq_holdoff_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .start_i(hold_start),
    .busy_o (hold_busy)
  );

  assign step_adv = ev.clk & run_q & ~hold_busy & ~hold_start;

  seq_step_counter #(.STEPS(STEPS)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ev.rst),
    .adv_i (step_adv),
    .step_o(step_o)
  );

  assign running_o = run_q;

endmodule

// File: rtl/step_seq_holdoff_chk.sv
module step_seq_holdoff_chk #(
  parameter int unsigned STEPS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick_en,
  input logic                     hold_busy,
  input logic [$clog2(STEPS)-1:0] step_o,
  input logic                     running_o
);

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o < STEPS);

  // R3
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_o) |-> (step_o == 0 || step_o == $past(step_o) + 1'b1));

  // R10
  step_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(step_o));

  // R2
  run_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(running_o));

  // R7
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && hold_busy) |=> (step_o == 0 || $stable(step_o)));

  // R5
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !running_o) |=> (step_o == 0 || $stable(step_o)));

endmodule

bind step_seq_holdoff step_seq_holdoff_chk #(.STEPS(STEPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .hold_busy(hold_busy),
  .step_o   (step_o),
  .running_o(running_o)
);

// File: tb/step_seq_holdoff_bench.sv
`timescale 1ns/100ps
module step_seq_holdoff_bench;

  localparam int unsigned STEPS = 4;
  localparam int unsigned HOLD  = 4;
  localparam int unsigned NVEC  = 29;

  // Row: [5]=reset_trig [4]=run_trig [3]=seq_clk [2:1]=expected step [0]=expected running
  localparam logic [5:0] VEC [0:NVEC-1] = '{
    6'b010_00_1, // R2 R8 run on, window opens
    6'b001_00_1, // R8 edge right after run on ignored
    6'b000_00_1,
    6'b000_00_1,
    6'b000_00_1,
    6'b001_01_1, // R3 advance
    6'b000_01_1,
    6'b001_10_1,
    6'b000_10_1,
    6'b001_11_1,
    6'b000_11_1,
    6'b001_00_1, // R4 wrap
    6'b010_00_0, // R2 stop
    6'b001_00_0, // R5 edge while stopped ignored
    6'b000_00_0,
    6'b010_00_1, // R8 run on again
    6'b000_00_1,
    6'b000_00_1,
    6'b000_00_1,
    6'b000_00_1,
    6'b001_01_1,
    6'b000_01_1,
    6'b100_00_1, // R6 reset, running kept
    6'b001_00_1, // R7 ignored
    6'b000_00_1,
    6'b000_00_1,
    6'b001_00_1, // R7 last tick inside window ignored
    6'b000_00_1,
    6'b001_01_1
  };

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       seq_clk_i;
  logic       reset_trig_i;
  logic       run_trig_i;
  logic [1:0] step_o;
  logic       running_o;

  int n_tests;
  int n_fail;

  step_seq_holdoff #(.STEPS(STEPS), .HOLD_TICKS(HOLD)) u_step_seq_holdoff (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .seq_clk_i   (seq_clk_i),
    .reset_trig_i(reset_trig_i),
    .run_trig_i  (run_trig_i),
    .step_o      (step_o),
    .running_o   (running_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [1:0] es, input logic er);
    n_tests++;
    if (step_o !== es || running_o !== er) begin
      n_fail++;
      $display("FAIL %s: step=%0d running=%0b expected step=%0d running=%0b",
               tag, step_o, running_o, es, er);
    end
  endtask

  task automatic tick(input logic r, input logic u, input logic c);
    @(negedge clk);
    reset_trig_i = r;
    run_trig_i   = u;
    seq_clk_i    = c;
    tick_en      = 1'b1;
    @(negedge clk);
    tick_en      = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n        = 1'b0;
    tick_en      = 1'b0;
    seq_clk_i    = 1'b0;
    reset_trig_i = 1'b0;
    run_trig_i   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 2'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      tick(VEC[i][5], VEC[i][4], VEC[i][3]);
      check($sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R8)", i), VEC[i][2:1], VEC[i][0]);
    end

    // R10: clock toggling with no tick is not seen
    tick(1'b0, 1'b0, 1'b0);
    @(negedge clk); seq_clk_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no tick, no advance", 2'd1, 1'b1);
    seq_clk_i = 1'b0;
    tick(1'b0, 1'b0, 1'b0);
    check("R10 level between ticks dropped", 2'd1, 1'b1);

    // R7: first tick after the window advances
    tick(1'b1, 1'b0, 1'b0);
    check("R6 reset clears step", 2'd0, 1'b1);
    for (int k = 0; k < HOLD; k++) tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    check("R7 first tick after window advances", 2'd1, 1'b1);

    // R9: second reset inside window restarts it
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    check("R9 restarted window drops edge", 2'd0, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    check("R10 dropped edge not replayed", 2'd0, 1'b1);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    check("R9 edge after restarted window advances", 2'd1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule